// File: doc/BRIEF.md
# Fault Event Log Writer

This block turns translation fault reports into fixed 16-byte records and appends them to a circular log held in system memory. A fault request carries the requester ID, the domain ID, the faulting address, an event code, and present and write flags. The block formats the record, issues one memory write at log base plus tail offset, and advances the tail once that write has been accepted.

Software programs the block through a small register port. The port holds a control word, the log base and size, the head and tail offsets, and a status word. The status word reports whether logging is running, has a sticky interrupt bit, and has a sticky overflow bit. Once overflow is flagged, the block drops new faults until software clears the bit. The head offset is only stored and read back; the block does not act on it. An interrupt request output is the AND of the interrupt status bit and its enable.

Register selects on `cfg_sel` are: 0 control, 1 base, 2 head, 3 tail, 4 status. Any other select reads as zero.

Top module: `fault_log_writer`

## Requirements
- R1: After reset the control, head, tail and status registers read zero, the base register reads 64'h0800_0000_0000_0000 (size code 8, base 0), no memory write is pending and `irq` is low.
- R2: A record is 128 bits, little-endian: bits 15:0 requester ID, bits 31:16 zero, bits 47:32 domain ID, bits 63:48 info, bits 127:64 faulting address.
- R3: The write address is the base (base register bits 51:12, 4 KiB aligned) plus the tail offset. Once `mem_wvalid` rises, it stays high with stable address and data until `mem_wready` is seen.
- R4: A fault is logged only when control bit 0 (global enable) and control bit 2 (log enable) are both 1. Status bit 3 reads 1 exactly then. Otherwise the fault is consumed with no memory write.
- R5: Each accepted memory write advances the tail by 16 and sets status bit 1.
- R6: The log length in bytes is 2 to the power of the size code in base register bits 59:56. When the advanced tail reaches that length, the tail becomes 0 and status bit 0 (overflow) is set.
- R7: While status bit 0 is 1, faults are dropped with no write. Writing 1 to status bit 0 or bit 1 clears that bit. Writing 0 leaves it unchanged. A set by the hardware in the same cycle wins over a clear.
- R8: `irq` equals status bit 1 AND control bit 3.
- R9: The info field holds the event code in bits 15:12. For code 2 (page fault), bit 4 holds the present flag and bit 5 the write flag. For any other code, bits 11:0 are zero.
- R10: Writes to the head or tail register keep bits 18:4 and read back with bits 3:0 zero. The head value has no effect on logging.
- R11: If an enabled, non-overflowed fault arrives while the tail is at or beyond the log length, it is dropped with no write and status bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for cfg_sel (combinational) |
| flt_valid | input | 1 | Fault request valid |
| flt_ready | output | 1 | Block idle, fault is taken this cycle |
| flt_code | input | 4 | Event code |
| flt_rid | input | 16 | Requester ID |
| flt_dom | input | 16 | Domain ID |
| flt_addr | input | 64 | Faulting address |
| flt_present | input | 1 | Page was present |
| flt_write | input | 1 | Access was a write |
| mem_wvalid | output | 1 | Memory write request |
| mem_wready | input | 1 | Memory write accepted |
| mem_waddr | output | 64 | Memory write byte address |
| mem_wdata | output | 128 | Record being written |
| irq | output | 1 | Event interrupt request |

## Verification
Assertions check on every cycle that:
- a pending memory write holds its address and data until accepted;
- a completed write always either steps the tail by 16 or wraps it to zero with overflow set;
- a completed write leaves the interrupt bit set;
- a fault that arrives while disabled or overflowed never starts a write.

Only the bench scenarios can show the rest:
- the exact record bits and the event code and flag placement;
- the wrap point for a chosen size code;
- write-one-to-clear against write-zero on the status word;
- that the head register has no effect;
- the drop of a fault when software has left the tail beyond the log end.

// File: rtl/fault_log_writer.sv
module fault_log_writer #(
  parameter int PA_W = 52,
  parameter int TAIL_W = 19,
  parameter logic [3:0] RST_SIZE = 4'd8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_sel,
  input  logic [63:0]  cfg_wdata,
  output logic [63:0]  cfg_rdata,
  input  logic         flt_valid,
  output logic         flt_ready,
  input  logic [3:0]   flt_code,
  input  logic [15:0]  flt_rid,
  input  logic [15:0]  flt_dom,
  input  logic [63:0]  flt_addr,
  input  logic         flt_present,
  input  logic         flt_write,
  output logic         mem_wvalid,
  input  logic         mem_wready,
  output logic [63:0]  mem_waddr,
  output logic [127:0] mem_wdata,
  output logic         irq
);
  localparam logic [2:0] SEL_CTL = 3'd0;
  localparam logic [2:0] SEL_BASE = 3'd1;
  localparam logic [2:0] SEL_HEAD = 3'd2;
  localparam logic [2:0] SEL_TAIL = 3'd3;
  localparam logic [2:0] SEL_STS = 3'd4;
  localparam int BASE_PAD = 56 - PA_W;
  localparam logic [TAIL_W:0] REC_STEP = (TAIL_W+1)'(16);
  localparam logic [TAIL_W:0] ONE = (TAIL_W+1)'(1);

  logic ctl_en, ctl_log, ctl_ie;
  logic [PA_W-1:12] base_q;
  logic [3:0] size_q;
  logic [TAIL_W-1:0] head_q, tail_q;
  logic ovf_q, intr_q, busy_q;
  logic [63:0] addr_q;
  logic [127:0] data_q;

  logic running, accept, take, full_hit, done, wrap;
  logic [TAIL_W:0] log_len, tail_inc;
  logic [15:0] info;

  assign running  = ctl_en & ctl_log;
  assign log_len  = ONE << size_q;
  assign accept   = flt_valid & ~busy_q;
  assign take     = accept & running & ~ovf_q & ({1'b0, tail_q} < log_len);
  assign full_hit = accept & running & ~ovf_q & ({1'b0, tail_q} >= log_len);
  assign done     = busy_q & mem_wready;
  assign tail_inc = {1'b0, tail_q} + REC_STEP;
  assign wrap     = tail_inc >= log_len;
  assign info     = (flt_code == 4'd2) ? {flt_code, 6'd0, flt_write, flt_present, 4'd0}
                                       : {flt_code, 12'd0};

  assign flt_ready  = ~busy_q;
  assign mem_wvalid = busy_q;
  assign mem_waddr  = addr_q;
  assign mem_wdata  = data_q;
  assign irq        = intr_q & ctl_ie;

  always_comb begin
    case (cfg_sel)
      SEL_CTL:  cfg_rdata = {60'd0, ctl_ie, ctl_log, 1'b0, ctl_en};
      SEL_BASE: cfg_rdata = {4'd0, size_q, {BASE_PAD{1'b0}}, base_q, 12'd0};
      SEL_HEAD: cfg_rdata = {{(64-TAIL_W){1'b0}}, head_q};
      SEL_TAIL: cfg_rdata = {{(64-TAIL_W){1'b0}}, tail_q};
      SEL_STS:  cfg_rdata = {60'd0, running, 1'b0, intr_q, ovf_q};
      default:  cfg_rdata = 64'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_log <= 1'b0; ctl_ie <= 1'b0;
      base_q <= '0; size_q <= RST_SIZE;
      head_q <= '0; tail_q <= '0;
      ovf_q <= 1'b0; intr_q <= 1'b0; busy_q <= 1'b0;
      addr_q <= '0; data_q <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_CTL: begin
            ctl_en <= cfg_wdata[0]; ctl_log <= cfg_wdata[2]; ctl_ie <= cfg_wdata[3];
          end
          SEL_BASE: begin
            base_q <= cfg_wdata[PA_W-1:12]; size_q <= cfg_wdata[59:56];
          end
          SEL_HEAD: head_q <= {cfg_wdata[TAIL_W-1:4], 4'd0};
          SEL_TAIL: tail_q <= {cfg_wdata[TAIL_W-1:4], 4'd0};
          SEL_STS: begin
            if (cfg_wdata[0]) ovf_q <= 1'b0;
            if (cfg_wdata[1]) intr_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (take) begin
        busy_q <= 1'b1;
        addr_q <= {{(64-PA_W){1'b0}}, base_q, 12'd0} + {{(64-TAIL_W){1'b0}}, tail_q};
        data_q <= {flt_addr, info, flt_dom, 16'd0, flt_rid};
      end
      if (full_hit) ovf_q <= 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        intr_q <= 1'b1;
        if (wrap) begin
          tail_q <= '0;
          ovf_q <= 1'b1;
        end else begin
          tail_q <= tail_inc[TAIL_W-1:0];
        end
      end
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));
  // R4
  drop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready && !(ctl_en && ctl_log)) |=> !mem_wvalid);
  // R5
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && mem_wready) |=> ((tail_q == $past(tail_q) + 5'd16) || (tail_q == '0 && ovf_q)));
  // R5
  intr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && mem_wready) |=> intr_q);
  // R7
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready && ovf_q) |=> !mem_wvalid);
endmodule

// File: tb/fault_log_writer_bench.sv
module fault_log_writer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [63:0] cfg_wdata = 0, cfg_rdata;
  logic flt_valid = 0, flt_ready;
  logic [3:0] flt_code = 0;
  logic [15:0] flt_rid = 0, flt_dom = 0;
  logic [63:0] flt_addr = 0;
  logic flt_present = 0, flt_write = 0;
  logic mem_wvalid, mem_wready = 0;
  logic [63:0] mem_waddr;
  logic [127:0] mem_wdata;
  logic irq;

  int total = 0, bad = 0, cyc = 0, nwr = 0;
  bit finished = 0;
  logic [63:0] cap_addr, rd;
  logic [127:0] cap_data;

  fault_log_writer u_fault_log_writer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit m_en, m_log, m_ie, m_ovf, m_intr, m_busy;
  logic [63:0] m_base, m_tail, m_addr;
  int m_size;
  logic [127:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_log = 0; m_ie = 0; m_ovf = 0; m_intr = 0; m_busy = 0;
      m_base = 0; m_tail = 0; m_size = 8; m_addr = 0; m_data = 0;
    end else begin
      automatic bit o_run = m_en && m_log, o_ovf = m_ovf, o_busy = m_busy;
      automatic logic [63:0] o_tail = m_tail, o_base = m_base;
      automatic longint o_len = longint'(1) << m_size;
      automatic logic [15:0] inf;
      if (cfg_we) begin
        if (cfg_sel == 0) begin m_en = cfg_wdata[0]; m_log = cfg_wdata[2]; m_ie = cfg_wdata[3]; end
        if (cfg_sel == 1) begin m_base = {12'd0, cfg_wdata[51:12], 12'd0}; m_size = int'(cfg_wdata[59:56]); end
        if (cfg_sel == 3) m_tail = {45'd0, cfg_wdata[18:4], 4'd0};
        if (cfg_sel == 4) begin if (cfg_wdata[0]) m_ovf = 0; if (cfg_wdata[1]) m_intr = 0; end
      end
      if (flt_valid && !o_busy && o_run && !o_ovf) begin
        if (longint'(o_tail) < o_len) begin
          inf = {flt_code, 12'd0};
          if (flt_code == 2) begin inf[4] = flt_present; inf[5] = flt_write; end
          m_busy = 1; m_addr = o_base + o_tail;
          m_data = {flt_addr, inf, flt_dom, 16'd0, flt_rid};
        end else m_ovf = 1;
      end
      if (o_busy && mem_wready) begin
        m_busy = 0; m_intr = 1;
        if (longint'(o_tail) + 16 >= o_len) begin m_tail = 0; m_ovf = 1; end
        else m_tail = o_tail + 16;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && mem_wvalid && mem_wready) begin nwr++; cap_addr = mem_waddr; cap_data = mem_wdata; end
    #1 mem_wready = (cyc % 3) != 1;
  end

  always @(negedge clk) if (rst_n && !finished) begin
    total++;
    if (flt_ready !== !m_busy || mem_wvalid !== m_busy || irq !== (m_intr && m_ie) ||
        (m_busy && (mem_waddr !== m_addr || mem_wdata !== m_data))) begin
      bad++;
      $display("FAIL R3/R8 cycle %0d act=%0h/%0h/%0h/%0h exp=%0h/%0h/%0h/%0h",
               cyc, mem_wvalid, irq, mem_waddr, mem_wdata, m_busy, m_intr && m_ie, m_addr, m_data);
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [63:0] d);
    @(posedge clk); #1 cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic rdreg(input logic [2:0] s, output logic [63:0] d);
    @(posedge clk); #1 cfg_sel = s;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic fault(input logic [3:0] c, input logic [15:0] r, input logic [15:0] dm,
                       input logic [63:0] a, input logic p, input logic w);
    @(posedge clk); #1 flt_valid = 1; flt_code = c; flt_rid = r; flt_dom = dm;
    flt_addr = a; flt_present = p; flt_write = w;
    @(posedge clk); #1 flt_valid = 0;
    @(negedge clk);
    while (!flt_ready) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rdreg(0, rd); chk("R1 control", rd, 0);
    rdreg(1, rd); chk("R1 base", rd, 64'h0800_0000_0000_0000);
    rdreg(4, rd); chk("R1 status", rd, 0);
    rdreg(3, rd); chk("R1 tail", rd, 0);
    chk("R1 irq", irq, 0);

    fault(2, 16'h1111, 16'h2, 64'h1000, 1, 0);
    chk("R4 no write while disabled", nwr, 0);
    rdreg(3, rd); chk("R4 tail unchanged", rd, 0);

    wr(1, 64'h0600_0000_1234_5000);
    wr(0, 64'hD);
    rdreg(4, rd); chk("R4 running bit", rd, 64'h8);

    fault(2, 16'hABCD, 16'h0042, 64'hDEAD_BEEF_0000_1234, 1, 1);
    chk("R2 R9 record", cap_data, {64'hDEAD_BEEF_0000_1234, 16'h2030, 16'h0042, 16'h0000, 16'hABCD});
    chk("R3 address", cap_addr, 64'h1234_5000);
    rdreg(3, rd); chk("R5 tail step", rd, 16);
    rdreg(4, rd); chk("R5 intr status", rd, 64'hA);
    chk("R8 irq raised", irq, 1);

    fault(2, 16'h1, 16'h1, 64'h10, 0, 0);
    chk("R3 second address", cap_addr, 64'h1234_5010);
    fault(2, 16'h2, 16'h1, 64'h20, 0, 1);
    fault(2, 16'h3, 16'h1, 64'h30, 1, 0);
    chk("R6 four writes", nwr, 4);
    rdreg(3, rd); chk("R6 tail wrapped", rd, 0);
    rdreg(4, rd); chk("R6 overflow set", rd, 64'hB);

    fault(2, 16'h4, 16'h1, 64'h40, 0, 0);
    chk("R7 dropped while overflow", nwr, 4);
    wr(4, 64'h0);
    rdreg(4, rd); chk("R7 write zero no effect", rd, 64'hB);
    wr(4, 64'h1);
    rdreg(4, rd); chk("R7 overflow cleared", rd, 64'hA);
    wr(4, 64'h2);
    rdreg(4, rd); chk("R7 intr cleared", rd, 64'h8);
    chk("R8 irq dropped", irq, 0);

    fault(5, 16'h7777, 16'h0009, 64'hCAFE, 1, 1);
    chk("R9 non page fault info", cap_data, {64'hCAFE, 16'h5000, 16'h0009, 16'h0000, 16'h7777});
    chk("R3 addr after wrap", cap_addr, 64'h1234_5000);

    wr(2, 64'h1237);
    rdreg(2, rd); chk("R10 head masked", rd, 64'h1230);
    fault(2, 16'h8, 16'h1, 64'h80, 0, 0);
    chk("R10 head no effect", cap_addr, 64'h1234_5010);

    wr(3, 64'h8F);
    rdreg(3, rd); chk("R10 tail masked", rd, 64'h80);
    fault(2, 16'h9, 16'h1, 64'h90, 0, 0);
    chk("R11 no write past end", nwr, 6);
    rdreg(4, rd); chk("R11 overflow set", rd, 64'hB);

    wr(4, 64'h3);
    wr(3, 64'h0);
    wr(0, 64'h5);
    fault(2, 16'hA, 16'h1, 64'hA0, 0, 0);
    rdreg(4, rd); chk("R8 intr status set", rd, 64'hA);
    chk("R8 irq masked", irq, 0);
    wr(0, 64'hD);
    @(negedge clk); chk("R8 irq unmasked", irq, 1);

    repeat (3) @(posedge clk);
    summary();
  end
endmodule